// File: doc/BRIEF.md
# One-Time-Programmable Byte Write Controller

This block runs the byte-write transaction of an add-only memory: a 128-byte array whose bits can move from 1 to 0 but never back. It sits behind a byte-level link to a bus master. The master sends a write opcode, a low address byte, a high address byte and one data byte. On request, the block answers with an 8-bit CRC over those four bytes, so the master can confirm that the transfer arrived intact.

After the CRC has gone out, the block waits for a program-pulse indication, which stands for the high-voltage detect of a real part. When the pulse arrives, the block merges the data into the addressed byte by bitwise AND. It skips the merge if the status byte marks that 32-byte page as protected. It then offers the resulting stored byte for read-back.

An address above the highest valid location is folded into range before use. The CRC is computed on the folded value, so a master that computes the CRC on what it sent sees a mismatch. A bus reset abandons the transaction at any point without touching the array.

Top module: `otp_write_ctrl`

## Requirements
- R1: After `rst`, `tx_valid` is 0, the block waits for an opcode, and a byte request before any opcode returns FFh.
- R2: Each `tx_req` pulse produces `tx_valid` high for one cycle, one clock later, with the answer on `tx_byte`. After the opcode 0Fh, low address, high address and data byte, the first request returns CRC-8 over those four bytes in that order. The CRC uses polynomial x^8+x^5+x^4+1, the reflected constant 8Ch, an initial value of 00h, and takes each byte least significant bit first.
- R3: If the 16-bit address {high,low} exceeds 007Fh, the upper nine bits are cleared before use and before the CRC. Both the target location and the CRC use the folded address.
- R4: An unwritten location holds FFh. A program pulse arriving after the CRC has been read stores old AND data, so a bit is never set back to 1.
- R5: The first request after the pulse returns the stored byte at the selected address.
- R6: Bit p of `status_wp` (p = address bits 6:5) equal to 0 protects page p. A pulse then leaves the array unchanged, the read-back returns the unchanged byte, and later reads of the page still work.
- R7: One sequence commits exactly one byte. Data bytes received after the first data byte are ignored, and neighbouring locations are untouched.
- R8: `bus_reset` before the pulse returns the block to waiting for an opcode and leaves the array unchanged.
- R9: After the read-back byte, every further request returns FFh until a bus reset.
- R10: A program pulse outside the wait-for-pulse state (for example before the CRC has been read, or while idle) has no effect on the array.
- R11: An opcode other than 0Fh is rejected. The following bytes are ignored and requests return FFh until a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the controller (array is kept) |
| bus_reset | input | 1 | Transaction abort from the link, returns to opcode wait |
| rx_valid | input | 1 | A byte from the master is present on rx_byte |
| rx_byte | input | 8 | Byte from the master |
| tx_req | input | 1 | Master requests one byte from the block |
| prog_pulse | input | 1 | Programming-voltage detected indication |
| status_wp | input | 8 | Status byte 0; bits 3:0 are active-low page protect flags |
| tx_valid | output | 1 | Answer to a request is on tx_byte (one cycle) |
| tx_byte | output | 8 | Byte returned to the master |

## Verification
A wrong address fold or a wrong captured byte shows up in the CRC answer, which comes one cycle after the request that follows the data byte. A faulty merge or a faulty protect decision is visible in the read-back byte right after the pulse. Its effect on the array, such as a lost AND or a write into a protected page, is exposed by a later write to the same location, whose read-back must equal the accumulated AND. A state machine that does not honour an abort, or that accepts a pulse out of turn, leaves a changed location that the next all-ones write to it reveals through its read-back.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR_LO,
    ST_ADDR_HI,
    ST_DATA,
    ST_CRC,
    ST_PULSE,
    ST_VERIFY,
    ST_DONE
  } otp_state_e;

  localparam logic [7:0] OPC_WRITE   = 8'h0F;
  localparam logic [7:0] CRC_POLY_RF = 8'h8C;
  localparam logic [7:0] IDLE_BYTE   = 8'hFF;
endpackage

// File: rtl/otp_crc8.sv
module otp_crc8 #(
  parameter int N_BYTES = 4
) (
  input  logic [N_BYTES*8-1:0] bytes_in,
  output logic [7:0]           crc_out
);
  import otp_pkg::*;
  localparam int N_BITS = N_BYTES * 8;

  logic [N_BITS:0][7:0] chain;
  assign chain[0] = 8'h00;

  // one LFSR step per bit, byte 0 first, each byte LSB first
  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    logic fb;
    assign fb = chain[i][0] ^ bytes_in[i];
    assign chain[i+1] = {1'b0, chain[i][7:1]} ^ (fb ? CRC_POLY_RF : 8'h00);
  end

  assign crc_out = chain[N_BITS];
endmodule

// File: rtl/otp_byte_array.sv
module otp_byte_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // erased state of the cells is all ones
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  // read-first single-port RAM
  always_ff @(posedge clk) begin
    rdata <= mem[addr];
    if (we) mem[addr] <= wdata;
  end
endmodule

// File: rtl/otp_seq.sv
module otp_seq #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_reset,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              tx_req,
  input  logic              prog_pulse,
  input  logic [7:0]        status_wp,
  input  logic [7:0]        rd_data,
  input  logic [7:0]        crc_val,
  output logic [15:0]       eff_addr,
  output logic [7:0]        data_byte,
  output logic              we,
  output logic [7:0]        wdata,
  output otp_pkg::otp_state_e state,
  output logic              tx_valid,
  output logic [7:0]        tx_byte
);
  import otp_pkg::*;
  localparam logic [15:0] ADDR_MASK = 16'((1 << ADDR_W) - 1);

  logic [7:0] al_q, ah_q, data_q, verify_q;
  logic [PAGE_BITS-1:0] page;
  logic       protect;

  // folding clears every bit above the valid range
  assign eff_addr  = {ah_q, al_q} & ADDR_MASK;
  assign data_byte = data_q;
  assign page      = eff_addr[ADDR_W-1 -: PAGE_BITS];
  assign protect   = ~status_wp[page];
  assign wdata     = rd_data & data_q;
  assign we        = (state == ST_PULSE) && prog_pulse && !bus_reset && !protect;

  always_ff @(posedge clk) begin
    if (rst || bus_reset) begin
      state <= ST_CMD;
    end else begin
      case (state)
        ST_CMD:     if (rx_valid) state <= (rx_byte == OPC_WRITE) ? ST_ADDR_LO : ST_DONE;
        ST_ADDR_LO: if (rx_valid) state <= ST_ADDR_HI;
        ST_ADDR_HI: if (rx_valid) state <= ST_DATA;
        ST_DATA:    if (rx_valid) state <= ST_CRC;
        ST_CRC:     if (tx_req)   state <= ST_PULSE;
        ST_PULSE:   if (prog_pulse) state <= ST_VERIFY;
        ST_VERIFY:  if (tx_req)   state <= ST_DONE;
        default:    state <= state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      al_q     <= '0;
      ah_q     <= '0;
      data_q   <= '1;
      verify_q <= '1;
    end else begin
      if (rx_valid && state == ST_ADDR_LO) al_q   <= rx_byte;
      if (rx_valid && state == ST_ADDR_HI) ah_q   <= rx_byte;
      if (rx_valid && state == ST_DATA)    data_q <= rx_byte;
      if (state == ST_PULSE && prog_pulse && !bus_reset)
        verify_q <= protect ? rd_data : wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_byte  <= IDLE_BYTE;
    end else begin
      tx_valid <= tx_req;
      if (tx_req) begin
        case (state)
          ST_CRC:    tx_byte <= crc_val;
          ST_VERIFY: tx_byte <= verify_q;
          default:   tx_byte <= IDLE_BYTE;
        endcase
      end
    end
  end
endmodule

// File: rtl/otp_write_ctrl.sv
module otp_write_ctrl #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_BITS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_reset,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_req,
  input  logic       prog_pulse,
  input  logic [7:0] status_wp,
  output logic       tx_valid,
  output logic [7:0] tx_byte
);
  import otp_pkg::*;
  localparam int FRAME_BYTES = 4;

  logic [15:0]        eff_addr;
  logic [7:0]         data_byte, rd_data, wdata, crc_val;
  logic               mem_we;
  otp_state_e         st;

  otp_seq #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_seq (
    .clk(clk), .rst(rst), .bus_reset(bus_reset),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_req(tx_req),
    .prog_pulse(prog_pulse), .status_wp(status_wp),
    .rd_data(rd_data), .crc_val(crc_val),
    .eff_addr(eff_addr), .data_byte(data_byte),
    .we(mem_we), .wdata(wdata), .state(st),
    .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  otp_crc8 #(.N_BYTES(FRAME_BYTES)) u_crc (
    .bytes_in({data_byte, eff_addr[15:8], eff_addr[7:0], OPC_WRITE}),
    .crc_out(crc_val)
  );

  otp_byte_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_mem (
    .clk(clk), .we(mem_we), .addr(eff_addr[ADDR_W-1:0]),
    .wdata(wdata), .rdata(rd_data)
  );
endmodule

// File: rtl/otp_write_ctrl_chk.sv
module otp_write_ctrl_chk #(
  parameter int ADDR_W    = 7,
  parameter int PAGE_BITS = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_reset,
  input logic               tx_req,
  input logic               prog_pulse,
  input logic [7:0]         status_wp,
  input logic               tx_valid,
  input logic [7:0]         tx_byte,
  input logic               mem_we,
  input logic [7:0]         wdata,
  input logic [7:0]         rd_data,
  input logic [15:0]        eff_addr,
  input otp_pkg::otp_state_e st
);
  import otp_pkg::*;

  // R2
  tx_resp_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(tx_req));

  // R4
  never_set_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> ((wdata & ~rd_data) == 8'h00));

  // R6
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> status_wp[eff_addr[ADDR_W-1 -: PAGE_BITS]]);

  // R7
  single_commit_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (!mem_we && st == ST_VERIFY));

  // R8
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (st == ST_CMD));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && $past(st) == ST_DONE) |-> (tx_byte == IDLE_BYTE));

  // R10
  stray_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_pulse && st != ST_PULSE) |-> !mem_we);
endmodule

bind otp_write_ctrl otp_write_ctrl_chk #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_chk (
  .clk(clk), .rst(rst), .bus_reset(bus_reset), .tx_req(tx_req),
  .prog_pulse(prog_pulse), .status_wp(status_wp), .tx_valid(tx_valid),
  .tx_byte(tx_byte), .mem_we(mem_we), .wdata(wdata), .rd_data(rd_data),
  .eff_addr(eff_addr), .st(st)
);

// File: tb/otp_write_ctrl_tb.sv
module otp_write_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst, bus_reset, rx_valid, tx_req, prog_pulse;
  logic [7:0] rx_byte, status_wp, tx_byte;
  logic       tx_valid;
  int         n_checks = 0, n_fail = 0;
  logic [7:0] model [128];

  always #2 clk = ~clk;

  otp_write_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_reset(bus_reset), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .tx_req(tx_req), .prog_pulse(prog_pulse),
    .status_wp(status_wp), .tx_valid(tx_valid), .tx_byte(tx_byte)
  );

  function automatic logic [7:0] crc4(input logic [7:0] b0, b1, b2, b3);
    logic [7:0] c = 8'h00;
    logic [31:0] s = {b3, b2, b1, b0};
    for (int i = 0; i < 32; i++) begin
      logic f = c[0] ^ s[i];
      c = c >> 1;
      if (f) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic check8(input string req, input logic [7:0] act, exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic ask(output logic [7:0] got, output logic vld);
    @(negedge clk); tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0; got = tx_byte; vld = tx_valid;
  endtask

  task automatic pulse();
    @(negedge clk); prog_pulse = 1'b1;
    @(negedge clk); prog_pulse = 1'b0;
  endtask

  task automatic abort();
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
  endtask

  function automatic logic [6:0] fold(input logic [7:0] al, ah);
    logic [15:0] a = {ah, al};
    return a[6:0];
  endfunction

  // full sequence; checks CRC and read-back against the model
  task automatic full_write(input string req, input logic [7:0] al, ah, d);
    logic [7:0] g; logic v; logic [6:0] a;
    a = fold(al, ah);
    send(8'h0F); send(al); send(ah); send(d);
    ask(g, v);
    check8({req, " crc"}, g, crc4(8'h0F, {1'b0, a}, 8'h00, d));
    pulse();
    if (status_wp[a[6:5]]) model[a] = model[a] & d;
    ask(g, v);
    check8({req, " verify"}, g, model[a]);
    check8({req, " verify valid"}, {7'd0, v}, 8'd1);
    abort();
  endtask

  task automatic t_reset();
    logic [7:0] g; logic v;
    check8("R1 tx_valid after reset", {7'd0, tx_valid}, 8'd0);
    ask(g, v);
    check8("R1 idle byte", g, 8'hFF);
    check8("R2 valid one cycle after request", {7'd0, v}, 8'd1);
    @(negedge clk);
    check8("R2 valid drops", {7'd0, tx_valid}, 8'd0);
  endtask

  task automatic t_basic();
    logic [7:0] g; logic v;
    send(8'h0F); send(8'h05); send(8'h00); send(8'hA5);
    ask(g, v);
    check8("R2 crc basic", g, crc4(8'h0F, 8'h05, 8'h00, 8'hA5));
    pulse();
    model[5] = model[5] & 8'hA5;
    ask(g, v);
    check8("R4 R5 verify first write", g, 8'hA5);
    ask(g, v);
    check8("R9 after verify", g, 8'hFF);
    ask(g, v);
    check8("R9 still idle", g, 8'hFF);
    abort();
    full_write("R4 and-merge", 8'h05, 8'h00, 8'h3C);
    check8("R4 merged value", model[5], 8'h24);
  endtask

  task automatic t_fold();
    logic [7:0] g; logic v;
    send(8'h0F); send(8'h85); send(8'h01); send(8'h77);
    ask(g, v);
    check8("R3 folded crc", g, crc4(8'h0F, 8'h05, 8'h00, 8'h77));
    n_checks++;
    if (g == crc4(8'h0F, 8'h85, 8'h01, 8'h77)) begin
      n_fail++; $display("FAIL R3 crc matches unfolded actual=%02h", g);
    end
    pulse();
    model[5] = model[5] & 8'h77;
    ask(g, v);
    check8("R3 folded target", g, model[5]);
    abort();
    full_write("R3 fold low byte", 8'h90, 8'h00, 8'h81);
  endtask

  task automatic t_protect();
    status_wp = 8'hFB;
    full_write("R6 protected page", 8'h45, 8'h00, 8'h00);
    check8("R6 model untouched", model[7'h45], 8'hFF);
    full_write("R6 other page open", 8'h25, 8'h00, 8'hE1);
    status_wp = 8'hFF;
    full_write("R6 after unprotect", 8'h45, 8'h00, 8'hF0);
  endtask

  task automatic t_abort();
    logic [7:0] g; logic v;
    send(8'h0F); send(8'h60); send(8'h00); send(8'h00);
    ask(g, v);
    abort();
    pulse();
    full_write("R8 abort keeps array", 8'h60, 8'h00, 8'hFF);
  endtask

  task automatic t_stray();
    logic [7:0] g; logic v;
    pulse();
    send(8'h0F); send(8'h20); send(8'h00); send(8'h0F);
    pulse();
    ask(g, v);
    check8("R10 crc unaffected", g, crc4(8'h0F, 8'h20, 8'h00, 8'h0F));
    abort();
    full_write("R10 stray pulse no write", 8'h20, 8'h00, 8'hFF);
  endtask

  task automatic t_single();
    logic [7:0] g; logic v;
    send(8'h0F); send(8'h07); send(8'h00); send(8'hC3); send(8'h00);
    ask(g, v);
    check8("R7 extra byte ignored crc", g, crc4(8'h0F, 8'h07, 8'h00, 8'hC3));
    pulse();
    model[7] = model[7] & 8'hC3;
    ask(g, v);
    check8("R7 one byte committed", g, 8'hC3);
    pulse();
    abort();
    full_write("R7 neighbour untouched", 8'h08, 8'h00, 8'hFF);
    full_write("R7 target stable", 8'h07, 8'h00, 8'hFF);
  endtask

  task automatic t_badcmd();
    logic [7:0] g; logic v;
    send(8'hF0); send(8'h30); send(8'h00); send(8'h00);
    ask(g, v);
    check8("R11 bad opcode idle", g, 8'hFF);
    pulse();
    ask(g, v);
    check8("R11 still idle", g, 8'hFF);
    abort();
    full_write("R11 no write done", 8'h30, 8'h00, 8'hFF);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'hFF;
    rst = 1'b1; bus_reset = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    tx_req = 1'b0; prog_pulse = 1'b0; status_wp = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_fold();
    t_protect();
    t_abort();
    t_stray();
    t_single();
    t_badcmd();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule